// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policy

This block sits between a processor's load/store port and a memory that moves whole lines. It keeps sixteen lines of four 32-bit words each, one line per index. Reads and writes that find their line resident complete without touching memory. Any miss, whether from a read or a write, first brings the whole line into the cache. The access then completes against the cached copy.

A plain mode input chooses how writes reach memory. In write-back mode a write stays in the cache and marks the line dirty. The dirty line goes out to memory only when a conflicting miss evicts it or when software asks for a clean. In write-through mode every write is also sent to memory as the updated line, so the line never becomes dirty. A clean request names an address. If the line at that index is resident, holds that tag and is dirty, the line is written out and stays valid but clean.

The processor side uses a valid/ready handshake with back-pressure. A request is taken when `cpu_valid` and `cpu_ready` are both high on a rising clock edge. While `cpu_ready` is low, the requester must hold every request field stable. `cpu_ready` is only raised while `cpu_valid` is high, and read data is valid in the cycle `cpu_ready` is high. The memory side uses a request/acknowledge handshake. The controller holds `mem_req` and every memory field stable until it samples `mem_ack` high. That edge ends the transfer.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean. With no request pending, `mem_req` and `cpu_ready` are low, and the first access to any address is a miss.
- R2: The address fields are as follows. Bits [1:0] are ignored, bits [3:2] select the word within the line, bits [7:4] select the line, and bits [31:8] are the tag. A memory transfer carries the line address `cpu_addr[31:4]`, and word k sits at bits [32k+31:32k] of a line.
- R3: When a read misses a line that is invalid or clean, there is exactly one memory read (`mem_we`=0) of the requested line. `cpu_ready` stays low until the fill is done, and the requested word of the fetched line is then returned.
- R4: A read that hits completes in the cycle it is presented, with `cpu_ready` high and no memory transfer.
- R5: A write miss reads the whole line from memory before applying the write. Only the bytes whose `cpu_be` bit is set (bit b covers data bits [8b+7:8b]) change, and the other bytes keep the values fetched from memory.
- R6: In write-back mode (`wt_mode`=0), a write that hits completes in the cycle it is presented. It updates only the cache, makes no memory transfer, and marks the line dirty.
- R7: In write-through mode (`wt_mode`=1), every write performs one memory line write of the updated line and completes in the cycle that write is acknowledged. The cache holds the same data afterwards, and the line is never marked dirty, so a later eviction of that line writes nothing back.
- R8: A miss on an index holding a valid dirty line with another tag first writes the old line to its own line address, then reads the new line.
- R9: A clean request that matches a valid dirty line writes the line to memory and completes on the acknowledge. The line stays valid and becomes clean.
- R10: A clean request completes in the cycle it is presented, with no memory transfer, when the indexed line is invalid, clean, or holds a different tag.
- R11: Once `mem_req` is raised, it stays high, with `mem_we`, `mem_line_addr` and `mem_wline` unchanged, until `mem_ack` is sampled high. Each transfer is acknowledged exactly once.
- R12: `cpu_ready` is never high while `cpu_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_clean | input | 1 | 1 makes the request a line clean (overrides `cpu_write`) |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory transfer request |
| mem_ack | input | 1 | Memory acknowledge, ends the transfer |
| mem_we | output | 1 | 1 for a line write, 0 for a line read |
| mem_line_addr | output | 28 | Line address |
| mem_wline | output | 128 | Line data for writes |
| mem_rline | input | 128 | Line data for reads, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is a miss that must write back a dirty victim before fetching. For it to happen, a write-back-mode write must first dirty a line, and a conflicting tag must then arrive on the same index. The bench builds this in order: a read miss installs the line, a write hit dirties it, and a read to another tag at that index makes the controller write out the modified line before fetching. The bench then re-reads the first address to confirm the written-back data reached memory. The same preparation, followed by clean requests with matching and non-matching tags, reaches the clean cases. Write-through mode is entered only after dirty lines exist, to show that write-through writes and evictions leave no dirty state behind.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    DC_IDLE,
    DC_EVICT,
    DC_FILL,
    DC_THRU,
    DC_CLEAN
  } dc_state_e;
endpackage

// File: rtl/dcc_tag_store.sv
module dcc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 24,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             install_en,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             set_dirty,
  input  logic             clr_dirty,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             valid_q [NUM_LINES];
  logic             dirty_q [NUM_LINES];
  logic [TAG_W-1:0] tag_q   [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else begin
      if (install_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (set_dirty) begin
        dirty_q[idx] <= 1'b1;
      end else if (clr_dirty) begin
        dirty_q[idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) tag_q[idx] <= install_tag;
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign tag_o   = tag_q[idx];

  logic [IDX_W-1:0] chk_idx;
  always_ff @(posedge clk) chk_idx <= idx;

  assert_dirty_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_o |-> valid_o);

  assert_clean_keeps_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dirty |=> (valid_q[chk_idx] && !dirty_q[chk_idx]));
endmodule

// File: rtl/dcc_data_store.sv
module dcc_data_store #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int WOFF_W    = $clog2(LINE_WORDS),
  localparam int BE_W      = WORD_W / 8,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WOFF_W-1:0] off,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] merged_o,
  output logic [WORD_W-1:0] word_o
);
  logic [LINE_W-1:0] lines_q [NUM_LINES];

  assign line_o = lines_q[idx];
  assign word_o = line_o[off*WORD_W +: WORD_W];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign merged_o[w*WORD_W + b*8 +: 8] =
        (off == WOFF_W'(w) && wr_be[b]) ? wr_data[b*8 +: 8]
                                         : line_o[w*WORD_W + b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)    lines_q[idx] <= fill_line;
    else if (wr_en) lines_q[idx] <= merged_o;
  end

  assert_single_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && wr_en));
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wt_mode,
  input  logic cpu_valid,
  input  logic cpu_write,
  input  logic cpu_clean,
  input  logic hit,
  input  logic line_valid,
  input  logic line_dirty,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic mem_req,
  output logic mem_we,
  output logic sel_old,
  output logic sel_merged,
  output logic install_en,
  output logic set_dirty,
  output logic clr_dirty,
  output logic word_wr
);
  dc_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= DC_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    cpu_ready  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    sel_old    = 1'b0;
    sel_merged = 1'b0;
    install_en = 1'b0;
    set_dirty  = 1'b0;
    clr_dirty  = 1'b0;
    word_wr    = 1'b0;
    unique case (state_q)
      DC_IDLE: begin
        if (cpu_valid) begin
          if (cpu_clean) begin
            if (hit && line_dirty) state_d   = DC_CLEAN;
            else                   cpu_ready = 1'b1;
          end else if (hit) begin
            if (!cpu_write) begin
              cpu_ready = 1'b1;
            end else if (!wt_mode) begin
              cpu_ready = 1'b1;
              word_wr   = 1'b1;
              set_dirty = 1'b1;
            end else begin
              state_d = DC_THRU;
            end
          end else if (line_valid && line_dirty) begin
            state_d = DC_EVICT;
          end else begin
            state_d = DC_FILL;
          end
        end
      end
      DC_EVICT: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        sel_old = 1'b1;
        if (mem_ack) state_d = DC_FILL;
      end
      DC_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          install_en = 1'b1;
          state_d    = DC_IDLE;
        end
      end
      DC_THRU: begin
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        sel_merged = 1'b1;
        if (mem_ack) begin
          word_wr   = 1'b1;
          cpu_ready = 1'b1;
          state_d   = DC_IDLE;
        end
      end
      DC_CLEAN: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        sel_old = 1'b1;
        if (mem_ack) begin
          clr_dirty = 1'b1;
          cpu_ready = 1'b1;
          state_d   = DC_IDLE;
        end
      end
      default: state_d = DC_IDLE;
    endcase
  end

  assert_ready_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  assert_evict_before_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DC_EVICT && mem_ack) |=> (mem_req && !mem_we));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int BE_W      = WORD_W / 8,
  localparam int BOFF_W    = $clog2(BE_W),
  localparam int WOFF_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - WOFF_W - BOFF_W,
  localparam int LADDR_W   = TAG_W + IDX_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wt_mode,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_write,
  input  logic               cpu_clean,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic [BE_W-1:0]    cpu_be,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_line_addr,
  output logic [LINE_W-1:0]  mem_wline,
  input  logic [LINE_W-1:0]  mem_rline
);
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_off;
  logic              boff_unused;

  assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx     = cpu_addr[BOFF_W+WOFF_W +: IDX_W];
  assign req_off     = cpu_addr[BOFF_W +: WOFF_W];
  assign boff_unused = ^cpu_addr[BOFF_W-1:0];

  logic             line_valid, line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic             hit;
  logic             sel_old, sel_merged, install_en, set_dirty, clr_dirty, word_wr;
  logic [LINE_W-1:0] line_data, merged_line;

  assign hit = line_valid && (line_tag == req_tag);

  dcc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (req_idx),
    .install_en (install_en),
    .install_tag(req_tag),
    .set_dirty  (set_dirty),
    .clr_dirty  (clr_dirty),
    .valid_o    (line_valid),
    .dirty_o    (line_dirty),
    .tag_o      (line_tag)
  );

  dcc_data_store #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (req_idx),
    .off      (req_off),
    .fill_en  (install_en),
    .fill_line(mem_rline),
    .wr_en    (word_wr),
    .wr_data  (cpu_wdata),
    .wr_be    (cpu_be),
    .line_o   (line_data),
    .merged_o (merged_line),
    .word_o   (cpu_rdata)
  );

  dcc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_mode   (wt_mode),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_clean (cpu_clean),
    .hit       (hit),
    .line_valid(line_valid),
    .line_dirty(line_dirty),
    .mem_ack   (mem_ack),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .sel_old   (sel_old),
    .sel_merged(sel_merged),
    .install_en(install_en),
    .set_dirty (set_dirty),
    .clr_dirty (clr_dirty),
    .word_wr   (word_wr)
  );

  assign mem_line_addr = sel_old ? {line_tag, req_idx} : {req_tag, req_idx};
  assign mem_wline     = sel_merged ? merged_line : line_data;

  assert_line_fields_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_line_addr) && $stable(mem_wline)));

  assert_read_done_no_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_write && !cpu_clean) |-> !mem_req);

  assert_thru_write_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_write && !cpu_clean && wt_mode)
      |-> (mem_req && mem_ack && mem_we));
endmodule

// File: tb/tb_dcache_ctrl.sv
`timescale 1ns/1ps
module tb_dcache_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_mode = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_clean = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we;
  logic mem_ack = 1'b0;
  logic [27:0] mem_line_addr;
  logic [127:0] mem_wline;
  logic [127:0] mem_rline = '0;

  always #5 clk = ~clk;

  dcache_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_clean(cpu_clean), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_line_addr(mem_line_addr), .mem_wline(mem_wline), .mem_rline(mem_rline)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [127:0] init_line(input logic [27:0] la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = {la, 2'b00, 2'(w)} ^ 32'h5A5A_0000;
    return l;
  endfunction

  function automatic logic [31:0] init_word(input logic [31:0] a);
    logic [127:0] l;
    l = init_line(a[31:4]);
    return l[a[3:2]*32 +: 32];
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  // memory model
  logic [127:0] mem_q [logic [27:0]];
  int rd_n = 0, wr_n = 0, op_n = 0;
  logic        op_we [64];
  logic [27:0] op_a  [64];
  logic [127:0] last_wr_d;
  int lat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else if (mem_req && mem_ack) begin
      mem_ack <= 1'b0;
      lat = 0;
      op_we[op_n % 64] = mem_we;
      op_a[op_n % 64]  = mem_line_addr;
      op_n++;
      if (mem_we) begin
        mem_q[mem_line_addr] = mem_wline;
        last_wr_d = mem_wline;
        wr_n++;
      end else begin
        rd_n++;
      end
    end else if (mem_req) begin
      if (lat == 2) begin
        mem_ack   <= 1'b1;
        mem_rline <= mem_q.exists(mem_line_addr) ? mem_q[mem_line_addr]
                                                 : init_line(mem_line_addr);
      end else begin
        lat++;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic cl, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_clean = cl;
    cpu_addr = a; cpu_wdata = d; cpu_be = be;
    waits = 0;
    #2;
    while (!cpu_ready && waits < 500) begin
      @(negedge clk); #2;
      waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_clean = 1'b0;
  endtask

  logic [31:0] rd;
  int waits, r0, w0, o0;

  task automatic snap();
    r0 = rd_n; w0 = wr_n; o0 = op_n;
  endtask

  task automatic t_reset();
    #2;
    check("R1", "mem_req idle after reset", 128'(mem_req), 128'(0));
    check("R1", "cpu_ready idle after reset", 128'(cpu_ready), 128'(0));
    snap();
    access(0, 0, 32'h2000_1004, 0, 0, rd, waits);
    check("R1", "first access misses", 128'(waits > 0), 128'(1));
    check("R3", "one line read", 128'(rd_n - r0), 128'(1));
    check("R3", "no write on clean miss", 128'(wr_n - w0), 128'(0));
    check("R2", "fill line address", 128'(op_a[o0 % 64]), 128'(28'h200_0100));
    check("R3", "read miss data", 128'(rd), 128'(init_word(32'h2000_1004)));
  endtask

  task automatic t_read_hit();
    snap();
    access(0, 0, 32'h2000_100B, 0, 0, rd, waits);
    check("R4", "hit same cycle", 128'(waits), 128'(0));
    check("R4", "hit no memory", 128'(op_n - o0), 128'(0));
    check("R2", "word select ignores byte bits", 128'(rd), 128'(init_word(32'h2000_1008)));
  endtask

  task automatic t_wb_write_hit();
    wt_mode = 1'b0;
    snap();
    access(1, 0, 32'h2000_1008, 32'hDEAD_BEEF, 4'b0101, rd, waits);
    check("R6", "write hit same cycle", 128'(waits), 128'(0));
    check("R6", "write hit no memory", 128'(op_n - o0), 128'(0));
    access(0, 0, 32'h2000_1008, 0, 0, rd, waits);
    check("R6", "write hit data", 128'(rd), 128'(mrg(init_word(32'h2000_1008), 32'hDEAD_BEEF, 4'b0101)));
  endtask

  task automatic t_write_miss();
    snap();
    access(1, 0, 32'h2000_1054, 32'h1122_3344, 4'b0010, rd, waits);
    check("R5", "write miss fetches", 128'(rd_n - r0), 128'(1));
    check("R5", "write miss no memory write", 128'(wr_n - w0), 128'(0));
    check("R5", "write miss fetch first", 128'(op_we[o0 % 64]), 128'(0));
    access(0, 0, 32'h2000_1054, 0, 0, rd, waits);
    check("R5", "merged bytes", 128'(rd), 128'(mrg(init_word(32'h2000_1054), 32'h1122_3344, 4'b0010)));
  endtask

  task automatic t_evict();
    logic [127:0] exp_l;
    exp_l = init_line(28'h200_0100);
    exp_l[64 +: 32] = mrg(init_word(32'h2000_1008), 32'hDEAD_BEEF, 4'b0101);
    snap();
    access(0, 0, 32'h2000_2008, 0, 0, rd, waits);
    check("R8", "two transfers", 128'(op_n - o0), 128'(2));
    check("R8", "write back first", 128'(op_we[o0 % 64]), 128'(1));
    check("R8", "victim address", 128'(op_a[o0 % 64]), 128'(28'h200_0100));
    check("R8", "victim data", last_wr_d, exp_l);
    check("R8", "then fetch", 128'(op_we[(o0 + 1) % 64]), 128'(0));
    check("R11", "fetch address", 128'(op_a[(o0 + 1) % 64]), 128'(28'h200_0200));
    check("R3", "new line data", 128'(rd), 128'(init_word(32'h2000_2008)));
    snap();
    access(0, 0, 32'h2000_1008, 0, 0, rd, waits);
    check("R3", "clean victim no write", 128'(wr_n - w0), 128'(0));
    check("R11", "single fetch", 128'(rd_n - r0), 128'(1));
    check("R8", "written back value returns", 128'(rd), 128'(exp_l[64 +: 32]));
  endtask

  task automatic t_clean();
    access(1, 0, 32'h2000_1000, 32'hCAFE_F00D, 4'b1111, rd, waits);
    snap();
    access(0, 1, 32'h2000_1000, 0, 0, rd, waits);
    check("R9", "clean stalls", 128'(waits > 0), 128'(1));
    check("R9", "clean one write", 128'(wr_n - w0), 128'(1));
    check("R9", "clean address", 128'(op_a[o0 % 64]), 128'(28'h200_0100));
    check("R9", "clean data", 128'(last_wr_d[31:0]), 128'(32'hCAFE_F00D));
    snap();
    access(0, 1, 32'h2000_1000, 0, 0, rd, waits);
    check("R10", "clean of clean line", 128'(waits), 128'(0));
    check("R10", "clean of clean line no memory", 128'(op_n - o0), 128'(0));
    access(0, 0, 32'h2000_1000, 0, 0, rd, waits);
    check("R9", "line kept valid", 128'(waits), 128'(0));
    check("R9", "line kept data", 128'(rd), 128'(32'hCAFE_F00D));
    snap();
    access(0, 1, 32'h2000_10F0, 0, 0, rd, waits);
    check("R10", "clean of invalid line", 128'(waits), 128'(0));
    access(0, 1, 32'h3000_0050, 0, 0, rd, waits);
    check("R10", "clean with other tag", 128'(waits), 128'(0));
    check("R10", "no memory for skipped cleans", 128'(op_n - o0), 128'(0));
    access(0, 1, 32'h2000_1050, 0, 0, rd, waits);
    check("R9", "clean dirty line from write miss", 128'(wr_n - w0), 128'(1));
  endtask

  task automatic t_write_thru();
    logic [31:0] exp_w;
    wt_mode = 1'b1;
    exp_w = mrg(init_word(32'h2000_1004), 32'h0BAD_C0DE, 4'b1100);
    snap();
    access(1, 0, 32'h2000_1004, 32'h0BAD_C0DE, 4'b1100, rd, waits);
    check("R7", "through write stalls", 128'(waits > 0), 128'(1));
    check("R7", "one memory write", 128'(op_n - o0), 128'(1));
    check("R7", "write address", 128'(op_a[o0 % 64]), 128'(28'h200_0100));
    check("R7", "memory word", 128'(last_wr_d[63:32]), 128'(exp_w));
    check("R7", "memory keeps other word", 128'(last_wr_d[31:0]), 128'(32'hCAFE_F00D));
    snap();
    access(0, 0, 32'h2000_1004, 0, 0, rd, waits);
    check("R7", "cache updated", 128'(rd), 128'(exp_w));
    check("R4", "hit after through write", 128'(op_n - o0), 128'(0));
    snap();
    access(0, 0, 32'h2000_2000, 0, 0, rd, waits);
    check("R7", "no write back after through write", 128'(wr_n - w0), 128'(0));
    snap();
    access(1, 0, 32'h2000_1060, 32'h7777_7777, 4'b1111, rd, waits);
    check("R7", "miss fetch then write", 128'(op_n - o0), 128'(2));
    check("R5", "fetch precedes write", 128'(op_we[o0 % 64]), 128'(0));
    check("R7", "miss write lands", 128'(last_wr_d[31:0]), 128'(32'h7777_7777));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_hit();
    t_wb_write_hit();
    t_write_miss();
    t_evict();
    t_clean();
    t_write_thru();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule